// File: doc/BRIEF.md
# Frame-Aware Byte FIFO with Level Alarm

This block is a synchronous byte FIFO that knows where frames end. Every write may carry an end-of-frame mark. The mark comes from a per-byte input or from a sticky control bit. The block keeps a frame-boundary pointer, which splits the stored bytes into two parts. Bytes between the read pointer and the boundary pointer belong to whole frames. Bytes between the boundary pointer and the write pointer belong to one frame still being written. A discard command removes that unfinished tail, so a producer that aborts a frame leaves only complete frames behind.

A small register port holds four registers. The first holds the framing controls and the discard command. The second gives direct access to the boundary pointer. The third holds an alarm threshold. The fourth clears the error flags. The alarm watches one of two quantities, chosen by an input. In receive use it watches the stored byte count, which warns that the FIFO is filling. In transmit use it watches free space, which warns that the FIFO is draining. The alarm sets above the threshold and clears only below a small fixed granularity level, so it has hysteresis. The storage holds 1024 bytes by default. The read side is show-ahead: `rdData` presents the oldest byte whenever the FIFO is not empty.

Top module: `frame_fifo`

## Requirements
- R1: Bytes leave in the order they were written. `count` equals bytes accepted minus bytes popped, plus any change made by a discard. `empty` is high at count 0 and `full` is high at count 1024.
- R2: A write while full is dropped and sets `overflow`. A pop while empty is dropped and sets `underflow`. Both flags stay set until any write to register 3, which clears them.
- R3: An accepted write becomes a frame boundary when `wrLast` is 1 or when control bit 1 (boundary-on-every-write) is set. After such a write, register 1 reads the storage index just past that byte, modulo 1024.
- R4: Writing register 0 with bit 0 (framing enable) and bit 2 (discard) both set moves the write pointer back to the boundary pointer. `count` drops by the number of unfinished bytes. A data write in the same cycle is dropped, and it does not set `overflow`.
- R5: A discard written with bit 0 clear has no effect on `count` or on the stored data.
- R6: Writing register 1 sets the boundary pointer to the written index. Reading register 1 returns that index, and a later discard returns the write pointer to it.
- R7: With `txMode` low, `alarm` rises on the cycle after `count` exceeds register 2.
- R8: With `txMode` high, `alarm` rises on the cycle after free space (1024 minus `count`) exceeds register 2.
- R9: Once set, `alarm` stays high while the watched quantity is at or above 4. It falls on the cycle after that quantity drops below 4.
- R10: After reset the FIFO is empty and `count` is 0. `alarm` and both flags are 0. Registers 1 and 2 read 0, and framing is disabled.
- R11: If pops have already reached into the unfinished frame, a discard empties the FIFO rather than moving the write pointer behind the read pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| txMode | input | 1 | 1: alarm watches free space; 0: alarm watches stored bytes |
| wrValid | input | 1 | Write request for `wrData` |
| wrData | input | 8 | Byte to store |
| wrLast | input | 1 | This byte ends a frame |
| rdReq | input | 1 | Pop the byte shown on `rdData` |
| rdData | output | 8 | Oldest stored byte (show-ahead) |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 control, 1 boundary pointer, 2 threshold, 3 flags |
| regWdata | input | 11 | Register write data |
| regRdata | output | 11 | Register read data for `regAddr` (combinational) |
| full | output | 1 | Storage full |
| empty | output | 1 | Storage empty |
| alarm | output | 1 | Level alarm with hysteresis |
| count | output | 11 | Stored byte count |
| overflow | output | 1 | Sticky dropped-write flag |
| underflow | output | 1 | Sticky dropped-pop flag |

## Verification
The assertions check these properties on every cycle:
- full and empty are never high together.
- The stored count never exceeds the storage size.
- A dropped write leaves the write pointer where it was, and a dropped pop leaves the read pointer where it was.
- The error flags stay set until they are cleared.
- After a discard, the write pointer sits at the boundary pointer.
- The alarm rises only after the threshold was exceeded and falls only after the watched quantity went below the granularity level.

Only the bench scenarios can show the following:
- Byte ordering across a full wrap of the storage.
- The exact boundary index after marked writes.
- That a disabled discard changes nothing.
- The clamp case, where pops have already reached into the unfinished frame.
- The alarm thresholds in both modes.

// File: rtl/ffifo_pkg.sv
`timescale 1ns/1ps
package ffifo_pkg;
  localparam int unsigned FfAddrW = 10;
  localparam int unsigned FfDataW = 8;
  localparam int unsigned FfGran  = 4;

  localparam logic [1:0] RegCtrl  = 2'd0;
  localparam logic [1:0] RegLwf   = 2'd1;
  localparam logic [1:0] RegAlarm = 2'd2;
  localparam logic [1:0] RegFlags = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;
  } memStrobe_t;
endpackage

// File: rtl/ffifo_store.sv
`timescale 1ns/1ps
module ffifo_store
  import ffifo_pkg::*;
#(
  parameter int unsigned ADDR_W = FfAddrW,
  parameter int unsigned DATA_W = FfDataW
) (
  input  logic              clk,
  input  memStrobe_t        strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.wrEn) mem[wrAddr] <= wrData;
  end

  assign rdData = mem[rdAddr];
endmodule

// File: rtl/ffifo_ctrl.sv
`timescale 1ns/1ps
module ffifo_ctrl
  import ffifo_pkg::*;
#(
  parameter int unsigned ADDR_W = FfAddrW,
  parameter int unsigned GRAN   = FfGran,
  localparam int unsigned PTR_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txMode,
  input  logic              wrValid,
  input  logic              wrLast,
  input  logic              rdReq,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [PTR_W-1:0]  regWdata,
  output logic [PTR_W-1:0]  regRdata,
  output memStrobe_t        strobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              full,
  output logic              empty,
  output logic              alarm,
  output logic [PTR_W-1:0]  count,
  output logic              overflow,
  output logic              underflow
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam logic [PTR_W-1:0] DepthV = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] GranV  = PTR_W'(GRAN);

  logic [PTR_W-1:0] wrPtr, rdPtr, lwfPtr, thresh;
  logic frmEn, wfcBit;

  // decoded register strobes
  logic ctrlWr, lwfWr, thrWr, flagClr;
  assign ctrlWr  = regWe && (regAddr == RegCtrl);
  assign lwfWr   = regWe && (regAddr == RegLwf);
  assign thrWr   = regWe && (regAddr == RegAlarm);
  assign flagClr = regWe && (regAddr == RegFlags);

  logic discardNow, rdAccept, wrAccept, boundary;
  assign count      = wrPtr - rdPtr;
  assign full       = (count == DepthV);
  assign empty      = (count == '0);
  assign discardNow = ctrlWr && regWdata[0] && regWdata[2];
  assign rdAccept   = rdReq && !empty;
  assign wrAccept   = wrValid && !full && !discardNow;
  assign boundary   = wrAccept && (wrLast || wfcBit);

  // discard target: boundary pointer, clamped to read side if pops passed it
  logic [PTR_W-1:0] rdPtrNext, partLen, heldLen, discardTarget;
  assign rdPtrNext     = rdPtr + PTR_W'(rdAccept);
  assign partLen       = wrPtr - lwfPtr;
  assign heldLen       = wrPtr - rdPtrNext;
  assign discardTarget = (partLen <= heldLen) ? lwfPtr : rdPtrNext;

  // software pointer write: rebuild wrap bit relative to write pointer
  logic [ADDR_W-1:0] swBack;
  logic [PTR_W-1:0]  swLwf;
  assign swBack = wrPtr[ADDR_W-1:0] - regWdata[ADDR_W-1:0];
  assign swLwf  = wrPtr - {1'b0, swBack};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      lwfPtr <= '0;
    end else begin
      rdPtr <= rdPtrNext;
      if (discardNow) begin
        wrPtr  <= discardTarget;
        lwfPtr <= discardTarget;
      end else begin
        if (wrAccept) wrPtr <= wrPtr + 1'b1;
        if (boundary)   lwfPtr <= wrPtr + 1'b1;
        else if (lwfWr) lwfPtr <= swLwf;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frmEn  <= 1'b0;
      wfcBit <= 1'b0;
      thresh <= '0;
    end else begin
      if (ctrlWr) begin
        frmEn  <= regWdata[0];
        wfcBit <= regWdata[1];
      end
      if (thrWr) thresh <= regWdata;
    end
  end

  // sticky error flags, set wins over clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      overflow  <= (wrValid && full && !discardNow) || (overflow && !flagClr);
      underflow <= (rdReq && empty) || (underflow && !flagClr);
    end
  end

  // level alarm with hysteresis
  logic [PTR_W-1:0] watched;
  logic alarmSet, alarmClr;
  assign watched  = txMode ? (DepthV - count) : count;
  assign alarmSet = watched > thresh;
  assign alarmClr = watched < GranV;

  always_ff @(posedge clk) begin
    if (!rstN)         alarm <= 1'b0;
    else if (alarmSet) alarm <= 1'b1;
    else if (alarmClr) alarm <= 1'b0;
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      RegCtrl:  regRdata = {{(PTR_W-2){1'b0}}, wfcBit, frmEn};
      RegLwf:   regRdata = {1'b0, lwfPtr[ADDR_W-1:0]};
      RegAlarm: regRdata = thresh;
      default:  regRdata = {{(PTR_W-2){1'b0}}, underflow, overflow};
    endcase
  end

  assign strobe.wrEn = wrAccept;
  assign wrAddr      = wrPtr[ADDR_W-1:0];
  assign rdAddr      = rdPtr[ADDR_W-1:0];

  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(full && empty)); // R1
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= DepthV); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (full && wrValid && !discardNow) |=> (wrPtr == $past(wrPtr)) && overflow); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (empty && rdReq) |=> (rdPtr == $past(rdPtr)) && underflow); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !flagClr) |=> overflow); // R2
  AST_DISCARD_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    discardNow |=> (wrPtr == lwfPtr) && (count <= $past(count))); // R4
  AST_ALARM_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarm) |-> $past(watched) > $past(thresh)); // R7
  AST_ALARM_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(alarm) |-> $past(watched) < GranV); // R9
endmodule

// File: rtl/frame_fifo.sv
`timescale 1ns/1ps
module frame_fifo
  import ffifo_pkg::*;
#(
  parameter int unsigned ADDR_W = FfAddrW,
  parameter int unsigned DATA_W = FfDataW,
  parameter int unsigned GRAN   = FfGran,
  localparam int unsigned PTR_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txMode,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrLast,
  input  logic              rdReq,
  output logic [DATA_W-1:0] rdData,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [PTR_W-1:0]  regWdata,
  output logic [PTR_W-1:0]  regRdata,
  output logic              full,
  output logic              empty,
  output logic              alarm,
  output logic [PTR_W-1:0]  count,
  output logic              overflow,
  output logic              underflow
);
  memStrobe_t        strobe;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  ffifo_ctrl #(.ADDR_W(ADDR_W), .GRAN(GRAN)) u_ctrl (
    .clk(clk), .rstN(rstN), .txMode(txMode),
    .wrValid(wrValid), .wrLast(wrLast), .rdReq(rdReq),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .full(full), .empty(empty), .alarm(alarm), .count(count),
    .overflow(overflow), .underflow(underflow)
  );

  ffifo_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .strobe(strobe), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: tb/test_frame_fifo.sv
`timescale 1ns/1ps
module test_frame_fifo;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txMode = 1'b0, wrValid = 1'b0, wrLast = 1'b0, rdReq = 1'b0, regWe = 1'b0;
  logic [7:0] wrData = '0;
  logic [1:0] regAddr = '0;
  logic [10:0] regWdata = '0;
  logic [7:0] rdData;
  logic [10:0] regRdata, count;
  logic full, empty, alarm, overflow, underflow;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  frame_fifo i_frame_fifo (
    .clk(clk), .rstN(rstN), .txMode(txMode), .wrValid(wrValid), .wrData(wrData),
    .wrLast(wrLast), .rdReq(rdReq), .rdData(rdData), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .full(full), .empty(empty), .alarm(alarm),
    .count(count), .overflow(overflow), .underflow(underflow)
  );

  // op[27:24] arg[23:12] exp[11:0]
  // ops: 0 push (arg[8]=last), 1 pop, 2 count, 3 boundary reg, 4 ctrl write
  localparam int NVEC = 33;
  localparam logic [27:0] VEC [NVEC] = '{
    {4'd4, 12'h001, 12'd0},
    {4'd0, 12'h011, 12'd0}, {4'd0, 12'h022, 12'd0}, {4'd0, 12'h133, 12'd0},
    {4'd2, 12'h000, 12'd3}, {4'd3, 12'h000, 12'd3},
    {4'd0, 12'h044, 12'd0}, {4'd0, 12'h055, 12'd0}, {4'd2, 12'h000, 12'd5},
    {4'd4, 12'h005, 12'd0}, {4'd2, 12'h000, 12'd3}, {4'd3, 12'h000, 12'd3},
    {4'd1, 12'h000, 12'h11}, {4'd1, 12'h000, 12'h22}, {4'd1, 12'h000, 12'h33},
    {4'd2, 12'h000, 12'd0},
    {4'd0, 12'h166, 12'd0}, {4'd0, 12'h077, 12'd0}, {4'd3, 12'h000, 12'd4},
    {4'd4, 12'h004, 12'd0}, {4'd2, 12'h000, 12'd2},
    {4'd1, 12'h000, 12'h66}, {4'd1, 12'h000, 12'h77},
    {4'd4, 12'h003, 12'd0}, {4'd0, 12'h088, 12'd0}, {4'd4, 12'h001, 12'd0},
    {4'd0, 12'h099, 12'd0}, {4'd3, 12'h000, 12'd6}, {4'd2, 12'h000, 12'd2},
    {4'd4, 12'h005, 12'd0}, {4'd2, 12'h000, 12'd1}, {4'd1, 12'h000, 12'h88},
    {4'd2, 12'h000, 12'd0}
  };

  task automatic chk(input string req, input int got, input int exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic last);
    @(negedge clk);
    wrValid = 1'b1; wrData = d; wrLast = last;
    @(negedge clk);
    wrValid = 1'b0; wrLast = 1'b0;
  endtask

  task automatic pop(input string req, input int exp, input bit doCheck);
    @(negedge clk);
    if (doCheck) chk(req, rdData, exp);
    rdReq = 1'b1;
    @(negedge clk);
    rdReq = 1'b0;
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [10:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output int v);
    @(negedge clk);
    regAddr = a;
    #1 v = regRdata;
  endtask

  task automatic alarmChk(input string req, input int exp);
    @(negedge clk);
    chk(req, alarm, exp);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int v;
    int base;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10 empty", empty, 1);
    chk("R10 full", full, 0);
    chk("R10 count", count, 0);
    chk("R10 alarm", alarm, 0);
    chk("R10 flags", {overflow, underflow}, 0);
    regRead(1, v); chk("R10 boundary reg", v, 0);
    regRead(2, v); chk("R10 threshold reg", v, 0);
    regRead(0, v); chk("R10 ctrl reg", v, 0);

    // table walk: ordering, boundaries, discard
    for (int k = 0; k < NVEC; k++) begin
      logic [3:0] op;
      logic [11:0] a;
      logic [11:0] e;
      op = VEC[k][27:24]; a = VEC[k][23:12]; e = VEC[k][11:0];
      case (op)
        4'd0: push(a[7:0], a[8]);
        4'd1: pop("R1 table pop", int'(e), 1'b1);
        4'd2: begin @(negedge clk); chk("R1 R4 R5 table count", count, int'(e)); end
        4'd3: begin regRead(1, v); chk("R3 table boundary", v, int'(e)); end
        default: regWrite(0, a[10:0]);
      endcase
    end

    // R2 underflow on empty
    pop("R2", 0, 1'b0);
    chk("R2 underflow set", underflow, 1);
    chk("R2 count after empty pop", count, 0);
    regWrite(3, 0);
    chk("R2 underflow cleared", underflow, 0);

    // R7 and R9 in receive mode
    regWrite(2, 5);
    for (int i = 0; i < 5; i++) push(8'h30 + 8'(i), 1'b0);
    alarmChk("R7 at threshold", 0);
    push(8'h35, 1'b0);
    alarmChk("R7 above threshold", 1);
    pop("R1", 8'h30, 1'b1);
    pop("R1", 8'h31, 1'b1);
    alarmChk("R9 hold at four", 1);
    pop("R1", 8'h32, 1'b1);
    alarmChk("R9 clear below four", 0);
    for (int i = 3; i < 6; i++) pop("R1", 8'h30 + i, 1'b1);

    // R8 transmit mode, then full-wrap fill with R9 and R2
    regWrite(2, 1024);
    txMode = 1'b1;
    alarmChk("R8 free equals threshold", 0);
    regWrite(2, 1023);
    alarmChk("R8 free above threshold", 1);
    for (int i = 0; i < 1024; i++) begin
      push(8'(i), 1'b0);
      if (i == 1019) alarmChk("R9 free four holds", 1);
      if (i == 1020) alarmChk("R9 free three clears", 0);
    end
    @(negedge clk);
    chk("R1 full", full, 1);
    chk("R1 count full", count, 1024);
    push(8'hEE, 1'b0);
    chk("R2 overflow set", overflow, 1);
    chk("R2 count unchanged", count, 1024);
    for (int i = 0; i < 1024; i++) pop("R1 wrap order", i & 8'hFF, 1'b1);
    chk("R1 empty after drain", empty, 1);
    txMode = 1'b0;
    regWrite(3, 0);
    chk("R2 overflow cleared", overflow, 0);

    // R4 write in same cycle as discard is dropped
    push(8'hA1, 1'b1);
    push(8'hB2, 1'b0);
    @(negedge clk);
    wrValid = 1'b1; wrData = 8'hC3; regWe = 1'b1; regAddr = 2'd0; regWdata = 11'd5;
    @(negedge clk);
    wrValid = 1'b0; regWe = 1'b0;
    chk("R4 count after discard", count, 1);
    chk("R4 no overflow", overflow, 0);
    pop("R4 survivor", 8'hA1, 1'b1);
    chk("R4 empty", empty, 1);

    // R6 software boundary pointer
    regRead(1, base);
    push(8'hD1, 1'b0); push(8'hD2, 1'b0); push(8'hD3, 1'b0);
    regWrite(1, 11'((base + 1) & 1023));
    regRead(1, v); chk("R6 readback", v, (base + 1) & 1023);
    regWrite(0, 5);
    chk("R6 count after discard", count, 1);
    pop("R6 kept byte", 8'hD1, 1'b1);

    // R11 discard after pops entered the unfinished frame
    push(8'hE1, 1'b0); push(8'hE2, 1'b0);
    pop("R11", 8'hE1, 1'b1);
    regWrite(0, 5);
    chk("R11 count", count, 0);
    chk("R11 empty", empty, 1);

    finish_run();
  end
endmodule